// File: doc/BRIEF.md
# Boot-Window Flash Command Sequencer

This block supervises cartridge boot on the console side. After reset it keeps the USB host controller in reset. It waits for the first console read that selects the cartridge ROM with address line A22 high, and then releases that reset. A fixed wait of `CD_TICKS` console clocks follows, and during that wait no Flash traffic is allowed. After the wait, ordinary console reads in the boot window are decoded by offset. Some offsets become Flash command writes. Some become Flash reads that feed only a 32-bit check word. The rest become Flash reads that go both to the console and into the check word.

Every ROM read in the live phase uses up one slot of a `BUDGET`-sized access budget. The budget count is cleared exactly once, on the first read that has A22 high. When the last slot is used, the block pulses a mailbox start strobe toward the controller, but only if the check word is then all ones. After the budget is used up, further ROM reads return zeros until the controller signals that boot mode has ended. A status bit tells the console when that has happened.

Top module: `cart_boot_gate`

## Requirements
- R1: `ctl_rst_n` is 0 from reset until a console read (`con_acc`, `con_rom`, `con_rd`, `con_a22` all 1). It goes to 1 at the clock edge that samples that read. ROM reads with `con_a22`=0, and writes, leave it at 0.
- R2: After the release, a wait of exactly `CD_TICKS` clocks runs. During the wait, reads raise neither `flash_re` nor `flash_we`, return 0 on `con_rdata`, and are not counted.
- R3: Live-phase reads with `con_a22`=1 at offsets 0x82, 0x83 and 0x84 raise `flash_we` in the same cycle with `flash_cmd` set to 0x60, 0x2F and 0x90 respectively, and return 0 to the console.
- R4: Live-phase reads with `con_a22`=1 at offsets 0x85 and 0x86 raise `flash_re`, fold the Flash word into the check word, and return 0 to the console.
- R5: A live-phase read with `con_a22`=1 at offset 0x87 raises `flash_we` with `flash_cmd` = 0xFF.
- R6: Live-phase reads with `con_a22`=1 at offsets 0x88 and above raise `flash_re`, return the Flash word to the console, and fold it into the check word. In the next cycle, `ctl_we` is 1 and `ctl_wdata` carries the updated check word. The check word is 0 after reset. The n-th folded word (counting from 0) is XORed into bits 15:0 when n is even and into bits 31:16 when n is odd.
- R7: Every live-phase ROM read is counted. The first read with `con_a22`=1 resets the count so that this read is number 1. Later reads with A22 high do not reset it. The read numbered `BUDGET` is the last one served. Reads with `con_a22`=0 return the Flash word and are not folded.
- R8: In the cycle after the last budget read, `mbox_go` pulses for exactly one cycle, and only if the check word, including that read, equals 0xFFFFFFFF.
- R9: `stat_ready` is 0 from reset until `boot_exit` arrives after the budget is spent. It is 1 from then on.
- R10: After the budget is spent, ROM reads return 0 with no Flash strobe. After `boot_exit`, ROM reads pass the Flash word through again.
- R11: Console writes (`con_rd`=0) produce no Flash strobe and use no budget.
- R12: Live-phase reads with `con_a22`=1 at offsets below 0x82 produce no Flash strobe and return 0, but they are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Console clock |
| rst | input | 1 | Synchronous active-high reset |
| con_acc | input | 1 | Console access strobe, one cycle per access |
| con_rom | input | 1 | Cartridge ROM select |
| con_a22 | input | 1 | Address line A22 (boot window) |
| con_rd | input | 1 | 1 for read, 0 for write |
| con_off | input | 16 | Offset within the boot window |
| con_rdata | output | WORD_W | Data returned to the console |
| stat_ready | output | 1 | Status poll bit: boot mode has ended |
| flash_re | output | 1 | Flash read strobe |
| flash_we | output | 1 | Flash command write strobe |
| flash_cmd | output | 8 | Flash command byte |
| flash_rdata | input | WORD_W | Flash read data |
| ctl_rst_n | output | 1 | Controller reset, active low |
| ctl_we | output | 1 | Check-word forward strobe |
| ctl_wdata | output | 2*WORD_W | Forwarded check word |
| mbox_go | output | 1 | Mailbox start strobe |
| boot_exit | input | 1 | Controller ends boot mode |

## Verification
The assertions check the following on every cycle:
- no Flash strobe occurs while the wait counter runs;
- the mailbox pulse is one cycle long and coincides with an all-ones check word;
- the check word holds when nothing is folded;
- the budget counter clears only once and steps by one;
- the status bit and the released controller reset never fall back.

Some behaviours can only be shown by the bench's scenarios. These are the exact offset-to-command mapping, the fold order across the two halves, and the exact read on which the budget expires. They also include whether the strobe fires or stays silent depending on the check word, and the zero-return and pass-through phases around `boot_exit`.

// File: rtl/cbg_pkg.sv
package cbg_pkg;

    localparam int OFF_W = 16;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_WAIT,
        ST_LIVE,
        ST_SPENT,
        ST_DONE
    } boot_st_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CMD,
        OP_HIDDEN,
        OP_SHOWN,
        OP_PLAIN
    } win_op_e;

    typedef struct packed {
        win_op_e    op;
        logic [7:0] cmd;
    } win_dec_t;

    localparam logic [7:0] FCMD_LOCK_SETUP = 8'h60;
    localparam logic [7:0] FCMD_LOCK_HARD  = 8'h2F;
    localparam logic [7:0] FCMD_READ_ID    = 8'h90;
    localparam logic [7:0] FCMD_READ_ARRAY = 8'hFF;
    localparam logic [OFF_W-1:0] OFF_FIRST_SHOWN = 16'h0088;

    function automatic win_dec_t decode_window(input logic [OFF_W-1:0] off);
        win_dec_t d;
        d.cmd = 8'h00;
        d.op  = OP_NONE;
        case (off)
            16'h0082: begin d.op = OP_CMD; d.cmd = FCMD_LOCK_SETUP; end
            16'h0083: begin d.op = OP_CMD; d.cmd = FCMD_LOCK_HARD;  end
            16'h0084: begin d.op = OP_CMD; d.cmd = FCMD_READ_ID;    end
            16'h0085: d.op = OP_HIDDEN;
            16'h0086: d.op = OP_HIDDEN;
            16'h0087: begin d.op = OP_CMD; d.cmd = FCMD_READ_ARRAY; end
            default:  d.op = (off >= OFF_FIRST_SHOWN) ? OP_SHOWN : OP_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cbg_countdown.sv
module cbg_countdown #(
    parameter int TICKS = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1;

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    assign busy = busy_q;
    assign last = busy_q && (cnt_q == CW'(TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start && !busy_q) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (last) busy_q <= 1'b0;
            else      cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cbg_fold.sv
module cbg_fold #(
    parameter int WORD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic [WORD_W-1:0]     word,
    output logic [2*WORD_W-1:0]   chk,
    output logic [2*WORD_W-1:0]   chk_nxt
);
    logic [2*WORD_W-1:0] chk_q;
    logic                hi_q;

    assign chk = chk_q;

    always_comb begin
        chk_nxt = chk_q;
        if (en) begin
            if (hi_q) chk_nxt[2*WORD_W-1:WORD_W] = chk_q[2*WORD_W-1:WORD_W] ^ word;
            else      chk_nxt[WORD_W-1:0]        = chk_q[WORD_W-1:0] ^ word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_q <= '0;
            hi_q  <= 1'b0;
        end else if (en) begin
            chk_q <= chk_nxt;
            hi_q  <= ~hi_q;
        end
    end

    AST_FOLD_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(chk_q)); // R6
endmodule

// File: rtl/cbg_budget.sv
module cbg_budget #(
    parameter int BUDGET = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic a22,
    output logic last
);
    localparam int CW = $clog2(BUDGET);
    localparam logic [CW-1:0] CNT_LAST = CW'(BUDGET - 1);

    logic [CW-1:0] cnt_q;
    logic          cleared_q;

    assign last = (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            cleared_q <= 1'b0;
        end else if (inc) begin
            if (a22 && !cleared_q) begin
                cnt_q     <= CW'(1);
                cleared_q <= 1'b1;
            end else if (!last) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_CLEAR_ONLY_ONCE: assert property (@(posedge clk) disable iff (rst)
        cleared_q |=> cleared_q); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && cleared_q && !last) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R7
endmodule

// File: rtl/cart_boot_gate.sv
module cart_boot_gate
    import cbg_pkg::*;
#(
    parameter int CD_TICKS = 32768,
    parameter int BUDGET   = 4096,
    parameter int WORD_W   = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  con_acc,
    input  logic                  con_rom,
    input  logic                  con_a22,
    input  logic                  con_rd,
    input  logic [OFF_W-1:0]      con_off,
    output logic [WORD_W-1:0]     con_rdata,
    output logic                  stat_ready,
    output logic                  flash_re,
    output logic                  flash_we,
    output logic [7:0]            flash_cmd,
    input  logic [WORD_W-1:0]     flash_rdata,
    output logic                  ctl_rst_n,
    output logic                  ctl_we,
    output logic [2*WORD_W-1:0]   ctl_wdata,
    output logic                  mbox_go,
    input  logic                  boot_exit
);
    localparam int CHK_W = 2 * WORD_W;

    boot_st_e           state_q;
    win_dec_t           dec;
    win_op_e            op;
    logic               rd_acc;
    logic               release_rd;
    logic               cd_busy;
    logic               cd_last;
    logic               bud_last;
    logic               bud_inc;
    logic               fold_en;
    logic [CHK_W-1:0]   chk;
    logic [CHK_W-1:0]   chk_nxt;
    logic               ctl_we_q;
    logic               mbox_q;

    assign rd_acc     = con_acc && con_rom && con_rd;
    assign release_rd = rd_acc && con_a22;
    assign dec        = decode_window(con_off);

    always_comb begin
        op = OP_NONE;
        if (state_q == ST_LIVE && rd_acc)
            op = con_a22 ? dec.op : OP_PLAIN;
    end

    assign bud_inc   = (state_q == ST_LIVE) && rd_acc;
    assign fold_en   = (op == OP_HIDDEN) || (op == OP_SHOWN);
    assign flash_we  = (op == OP_CMD);
    assign flash_cmd = (op == OP_CMD) ? dec.cmd : 8'h00;
    assign flash_re  = fold_en || (op == OP_PLAIN) || (state_q == ST_DONE && rd_acc);
    assign con_rdata = ((op == OP_SHOWN) || (op == OP_PLAIN) ||
                        (state_q == ST_DONE && rd_acc)) ? flash_rdata : '0;

    assign ctl_rst_n  = (state_q != ST_HOLD);
    assign stat_ready = (state_q == ST_DONE);
    assign ctl_we     = ctl_we_q;
    assign ctl_wdata  = chk;
    assign mbox_go    = mbox_q;

    cbg_countdown #(.TICKS(CD_TICKS)) u_wait (
        .clk   (clk),
        .rst   (rst),
        .start (state_q == ST_HOLD && release_rd),
        .busy  (cd_busy),
        .last  (cd_last)
    );

    cbg_budget #(.BUDGET(BUDGET)) u_budget (
        .clk  (clk),
        .rst  (rst),
        .inc  (bud_inc),
        .a22  (con_a22),
        .last (bud_last)
    );

    cbg_fold #(.WORD_W(WORD_W)) u_fold (
        .clk     (clk),
        .rst     (rst),
        .en      (fold_en),
        .word    (flash_rdata),
        .chk     (chk),
        .chk_nxt (chk_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_HOLD;
            ctl_we_q <= 1'b0;
            mbox_q   <= 1'b0;
        end else begin
            ctl_we_q <= (op == OP_SHOWN);
            mbox_q   <= bud_inc && bud_last && (chk_nxt == {CHK_W{1'b1}});
            case (state_q)
                ST_HOLD:  if (release_rd) state_q <= ST_WAIT;
                ST_WAIT:  if (cd_last) state_q <= ST_LIVE;
                ST_LIVE:  if (bud_inc && bud_last) state_q <= ST_SPENT;
                ST_SPENT: if (boot_exit) state_q <= ST_DONE;
                default:  state_q <= state_q;
            endcase
        end
    end

    AST_RESET_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!ctl_rst_n && !release_rd) |=> !ctl_rst_n); // R1
    AST_RELEASE_STICKS: assert property (@(posedge clk) disable iff (rst)
        ctl_rst_n |=> ctl_rst_n); // R1
    AST_NO_FLASH_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
        cd_busy |-> (!flash_re && !flash_we)); // R2
    AST_MBOX_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        mbox_go |-> (chk == {CHK_W{1'b1}})); // R8
    AST_MBOX_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mbox_go |=> !mbox_go); // R8
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        stat_ready |=> stat_ready); // R9
    AST_WRITE_NO_FLASH: assert property (@(posedge clk) disable iff (rst)
        (con_acc && !con_rd) |-> (!flash_re && !flash_we)); // R11
endmodule

// File: tb/cart_boot_gate_tb.sv
module cart_boot_gate_tb;
    localparam int CD    = 32768;
    localparam int BUD   = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        con_acc = 1'b0, con_rom = 1'b0, con_a22 = 1'b0, con_rd = 1'b0;
    logic [15:0] con_off = '0;
    logic [15:0] con_rdata;
    logic        stat_ready;
    logic        flash_re, flash_we;
    logic [7:0]  flash_cmd;
    logic [15:0] flash_rdata = '0;
    logic        ctl_rst_n, ctl_we, mbox_go;
    logic [31:0] ctl_wdata;
    logic        boot_exit = 1'b0;

    always #10 clk = ~clk;

    cart_boot_gate #(.CD_TICKS(CD), .BUDGET(BUD), .WORD_W(16)) u_dut (
        .clk(clk), .rst(rst), .con_acc(con_acc), .con_rom(con_rom), .con_a22(con_a22),
        .con_rd(con_rd), .con_off(con_off), .con_rdata(con_rdata), .stat_ready(stat_ready),
        .flash_re(flash_re), .flash_we(flash_we), .flash_cmd(flash_cmd),
        .flash_rdata(flash_rdata), .ctl_rst_n(ctl_rst_n), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .mbox_go(mbox_go), .boot_exit(boot_exit)
    );

    int n_pass = 0, n_fail = 0;
    int used;
    logic [31:0] m_chk;
    logic        m_hi;
    logic        s_re, s_we, s_cwe, s_mbox;
    logic [7:0]  s_cmd;
    logic [15:0] s_data;
    logic [31:0] s_cwd;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        if (act === exp) n_pass++;
        else begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fold(input logic [15:0] w);
        if (m_hi) m_chk[31:16] = m_chk[31:16] ^ w;
        else      m_chk[15:0]  = m_chk[15:0] ^ w;
        m_hi = ~m_hi;
    endtask

    task automatic access(input logic rd, input logic a22, input logic [15:0] off,
                          input logic [15:0] d);
        @(negedge clk);
        con_acc = 1'b1; con_rom = 1'b1; con_rd = rd; con_a22 = a22;
        con_off = off; flash_rdata = d;
        #1;
        s_re = flash_re; s_we = flash_we; s_cmd = flash_cmd; s_data = con_rdata;
        @(negedge clk);
        s_cwe = ctl_we; s_cwd = ctl_wdata; s_mbox = mbox_go;
        con_acc = 1'b0; con_rd = 1'b0; con_a22 = 1'b0; con_rom = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_chk = '0; m_hi = 1'b0; used = 0;
        @(negedge clk);
        check("R1 reset held", ctl_rst_n, 1'b0);
        check("R9 status low", stat_ready, 1'b0);
        check("R8 mbox idle", mbox_go, 1'b0);
        check("R2 no flash", {flash_re, flash_we}, 2'b00);
    endtask

    task automatic t_release();
        access(1'b1, 1'b0, 16'h0088, 16'h1111);
        check("R1 a22-low read keeps reset", ctl_rst_n, 1'b0);
        access(1'b0, 1'b1, 16'h0088, 16'h1111);
        check("R1 write keeps reset", ctl_rst_n, 1'b0);
        access(1'b1, 1'b1, 16'h0000, 16'h1111);
        check("R1 release", ctl_rst_n, 1'b1);
    endtask

    task automatic t_wait();
        access(1'b1, 1'b1, 16'h0088, 16'hBEEF);
        check("R2 early read blocked", {s_re, s_we}, 2'b00);
        check("R2 early data zero", s_data, 16'h0);
        repeat (CD - 5) @(negedge clk);
        access(1'b1, 1'b1, 16'h0082, 16'hBEEF);
        check("R2 late read blocked", {s_re, s_we}, 2'b00);
        check("R2 late data zero", s_data, 16'h0);
        repeat (2) @(negedge clk);
    endtask

    task automatic plain_read(input logic [15:0] d);
        access(1'b1, 1'b0, 16'h0400, d);
        used++;
        check("R7 plain read strobe", s_re, 1'b1);
        check("R7 plain read data", s_data, d);
        check("R7 plain not forwarded", s_cwe, 1'b0);
        check("R7 plain not folded", s_cwd, m_chk);
    endtask

    task automatic t_commands(input logic low_first);
        if (low_first) begin
            access(1'b1, 1'b1, 16'h0010, 16'h7777);
            used = 1;
            check("R12 low offset no strobe", {s_re, s_we}, 2'b00);
            check("R12 low offset data", s_data, 16'h0);
        end
        access(1'b1, 1'b1, 16'h0082, 16'h1234);
        used = low_first ? used + 1 : 1;
        check("R3 cmd 0x82 strobe", {s_re, s_we}, 2'b01);
        check("R3 cmd 0x82 value", s_cmd, 8'h60);
        check("R3 cmd data zero", s_data, 16'h0);
        access(1'b1, 1'b1, 16'h0083, 16'h1234);
        used++;
        check("R3 cmd 0x83 value", {s_we, s_cmd}, {1'b1, 8'h2F});
        access(1'b1, 1'b1, 16'h0084, 16'h1234);
        used++;
        check("R3 cmd 0x84 value", {s_we, s_cmd}, {1'b1, 8'h90});
        access(1'b1, 1'b1, 16'h0085, 16'hA1B2);
        used++; fold(16'hA1B2);
        check("R4 hidden 0x85 strobe", {s_re, s_we}, 2'b10);
        check("R4 hidden 0x85 masked", s_data, 16'h0);
        check("R4 hidden 0x85 no forward", s_cwe, 1'b0);
        access(1'b1, 1'b1, 16'h0086, 16'hC3D4);
        used++; fold(16'hC3D4);
        check("R4 hidden 0x86 masked", {s_re, s_data}, {1'b1, 16'h0});
        access(1'b1, 1'b1, 16'h0087, 16'h1234);
        used++;
        check("R5 cmd 0x87", {s_re, s_we, s_cmd}, {2'b01, 8'hFF});
    endtask

    task automatic t_fill(input logic make_ones);
        for (int i = 0; used < BUD; i++) begin
            logic [15:0] d;
            d = 16'h5A3C ^ 16'(i * 16'h0107);
            if (make_ones && (BUD - used) <= 2)
                d = m_hi ? ~m_chk[31:16] : ~m_chk[15:0];
            if (i == 50) begin
                access(1'b0, 1'b1, 16'h0088, 16'hFFFF);
                check("R11 write no strobe", {s_re, s_we}, 2'b00);
            end
            access(1'b1, 1'b1, 16'(16'h0088 + (i % 200)), d);
            used++; fold(d);
            check("R6 shown strobe+data", {s_re, s_data}, {1'b1, d});
            check("R6 forward strobe", s_cwe, 1'b1);
            check("R6 forwarded check", s_cwd, m_chk);
            if (used == BUD)
                check("R8 mbox at budget end", s_mbox, (m_chk == 32'hFFFF_FFFF));
            else if (s_mbox !== 1'b0)
                check("R8 mbox early", s_mbox, 1'b0);
        end
        @(negedge clk);
        check("R8 mbox single pulse", mbox_go, 1'b0);
    endtask

    task automatic t_spent_exit();
        access(1'b1, 1'b1, 16'h0090, 16'h9876);
        check("R10 spent read no strobe", {s_re, s_we}, 2'b00);
        check("R10 spent data zero", s_data, 16'h0);
        check("R9 status low while spent", stat_ready, 1'b0);
        @(negedge clk); boot_exit = 1'b1;
        @(negedge clk); boot_exit = 1'b0;
        check("R9 status after exit", stat_ready, 1'b1);
        access(1'b1, 1'b1, 16'h0090, 16'h4321);
        check("R10 done pass-through", {s_re, s_data}, {1'b1, 16'h4321});
        check("R9 status stays", stat_ready, 1'b1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
        $finish;
    end

    initial begin
        // Run A: A22 clear lands on a low offset, pattern data (mailbox per model)
        t_reset();
        t_release();
        t_wait();
        plain_read(16'h0A0A);
        plain_read(16'h0B0B);
        plain_read(16'h0C0C);
        t_commands(1'b1);
        t_fill(1'b0);
        t_spent_exit();
        // Run B: extra A22-high and plain reads after the clear, check forced to all ones
        t_reset();
        t_release();
        t_wait();
        plain_read(16'h1357);
        plain_read(16'h2468);
        t_commands(1'b0);
        plain_read(16'h0F0F);
        access(1'b1, 1'b1, 16'h0082, 16'h0000);
        used++;
        check("R7 second A22 read no reclear, cmd", {s_we, s_cmd}, {1'b1, 8'h60});
        t_fill(1'b1);
        check("R8 model reached all ones", m_chk, 32'hFFFF_FFFF);
        t_spent_exit();
        $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
        $finish;
    end
endmodule